// File: doc/BRIEF.md
# Depth-First Bus Numbering Sequencer

This block walks a tree of configuration-addressed functions in hardware and gives every bridge it meets a bus number. After a `start` pulse it probes bus 0 one slot at a time. A slot is a device (0 to 31) and a function (0 to 7). For each slot it first reads the 16-bit vendor identifier and then, if the function is present, reads the header-type byte. This tells it whether the device holds several functions and whether the function is a bridge. All traffic goes through a single request port that carries bus, device, function, byte offset and write data. There is never more than one request outstanding, and every request completes with a response carrying a status code.

When the sequencer finds a bridge, it writes the bridge's upstream, downstream and last-reachable bus number bytes. It then saves its place on an internal return stack and scans the newly numbered bus before it resumes the parent scan. When a subtree is finished, the bridge's last-reachable bus byte is rewritten with the highest bus number handed out inside that subtree. The stack depth is a parameter. A bridge found while the stack is full still gets a bus number, but nothing below it is scanned and a sticky error flag is raised.

When the whole tree is done, the block reports `done`, the number of present functions it found and the highest bus number it assigned. Firmware or a boot controller can use the result as the bus-numbered view of the tree.

Top module: `bus_enum_engine`

## Requirements
- R1: After reset, and while idle, `done`, `err_overflow`, `func_count` and `max_bus` are all 0 and no request is issued. A `start` pulse while idle or done clears the outputs and the stack and begins a scan of bus 0 at device 0, function 0.
- R2: Each slot is probed with a read at offset 00h. A completion with status 000b and data other than FFFFh marks the function present, and `func_count` increments. On each bus, devices are visited in ascending order from 0 to 31 and functions from 0 to 7.
- R3: If function 0 of a device reads as absent, functions 1 to 7 of that device are not probed, even if they would answer.
- R4: For a present function, the header byte at offset 0Eh is read. If function 0 has bit 7 of this byte clear, functions 1 to 7 of that device are skipped. If bit 7 is set, every function of the device is probed.
- R5: A header byte whose bits 6:0 equal 01h marks a bridge. The engine then writes offset 18h with the current bus, offset 19h with the next free bus number (the previous `max_bus` plus one) and offset 1Ah with FFh, in that order, and then scans the new bus before it continues the parent bus.
- R6: When the scan behind a bridge ends, the engine writes offset 1Ah of that bridge again, this time with the highest bus number assigned so far. `max_bus` always equals the highest bus number assigned, never decreases during a scan, and no request names a bus above it.
- R7: A completion with status 010b is not a result. The same request (same bus, device, function, offset and data) is reissued.
- R8: The stack holds `STACK_DEPTH` levels. A bridge found while the stack is full still receives its 18h, 19h and FFh writes, and its 1Ah byte is then rewritten with its own secondary bus number. `err_overflow` is set and stays set until the next `start`, and the bus behind that bridge is not scanned.
- R9: `req_valid` is high for a single cycle per request, and the next request follows only after a response. `done` rises after bus 0 has finished and holds, with no further requests, until the next `start`. Writes carry only offsets 18h, 19h and 1Ah.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new scan (accepted when idle or done) |
| req_valid | output | 1 | One-cycle request strobe |
| req_write | output | 1 | 1 = byte write, 0 = read |
| req_bus | output | BUS_W (8) | Target bus |
| req_dev | output | 5 | Target device |
| req_fn | output | 3 | Target function |
| req_off | output | 8 | Byte offset |
| req_wdata | output | BUS_W (8) | Write data byte |
| rsp_valid | input | 1 | Completion strobe |
| rsp_status | input | 3 | Completion status: 000b success, 010b retry |
| rsp_data | input | 16 | Read data (vendor id at 00h, header byte in bits 7:0 at 0Eh) |
| done | output | 1 | Scan complete |
| err_overflow | output | 1 | A bridge was found while the stack was full |
| func_count | output | CNT_W (16) | Present functions found |
| max_bus | output | BUS_W (8) | Highest bus number assigned |

## Verification
Most wrong internal states have a visible trace on the request port. A lost skip flag shows up as an extra probe of function 1. A wrongly restored return context becomes a subordinate rewrite aimed at the wrong bus, device or function as soon as a subtree ends. A stale `max_bus` becomes a wrong 19h byte on the very next bridge. The bench models the tree as bridges routed by the bus bytes actually written to them, so a misnumbered bridge hides its children. The error therefore appears in `func_count` at `done`, and in the bytes recorded for each bridge, within the same scan. Retry and stack overflow each get their own tree, so the damage from each one can be attributed.

// File: rtl/bus_enum_pkg.sv
package bus_enum_pkg;

  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int OFF_W = 8;
  localparam int DAT_W = 16;
  localparam int STS_W = 3;

  localparam logic [STS_W-1:0] CPL_OK    = 3'b000;
  localparam logic [STS_W-1:0] CPL_RETRY = 3'b010;

  localparam logic [OFF_W-1:0] OFF_VENDOR = 8'h00;
  localparam logic [OFF_W-1:0] OFF_HTYPE  = 8'h0E;
  localparam logic [OFF_W-1:0] OFF_PRIM   = 8'h18;
  localparam logic [OFF_W-1:0] OFF_SECB   = 8'h19;
  localparam logic [OFF_W-1:0] OFF_SUBB   = 8'h1A;

  localparam logic [DAT_W-1:0] VENDOR_NONE = 16'hFFFF;
  localparam logic [6:0]       HTYPE_BRIDGE = 7'h01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VID,
    ST_HDR,
    ST_PRI,
    ST_SEC,
    ST_SUB_OPEN,
    ST_SUB_CLOSE,
    ST_ADV,
    ST_DONE
  } scan_st_e;

endpackage

// File: rtl/bus_enum_stack.sv
module bus_enum_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] sp_q, sp_d;
  logic [W-1:0]     mem [DEPTH];
  logic [IDX_W-1:0] top_idx;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (sp_q == PTR_W'(g))) begin
          mem[g] <= din;
        end
      end
    end
  endgenerate

  always_comb begin
    sp_d = sp_q;
    if (clear) begin
      sp_d = '0;
    end else if (push && !full) begin
      sp_d = sp_q + 1'b1;
    end else if (pop && !empty) begin
      sp_d = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else begin
      sp_q <= sp_d;
    end
  end

  assign empty   = (sp_q == '0);
  assign full    = (sp_q == PTR_W'(DEPTH));
  assign top_idx = empty ? '0 : IDX_W'(sp_q - 1'b1);
  assign top     = mem[top_idx];

endmodule

// File: rtl/bus_enum_slot_walk.sv
module bus_enum_slot_walk
  import bus_enum_pkg::*;
(
  input  logic [DEV_W-1:0] dev,
  input  logic [FN_W-1:0]  fn,
  input  logic             skip_rest,
  output logic [DEV_W-1:0] nxt_dev,
  output logic [FN_W-1:0]  nxt_fn,
  output logic             bus_end
);
  logic dev_done;

  always_comb begin
    dev_done = skip_rest || (fn == '1);
    bus_end  = dev_done && (dev == '1);
    if (dev_done) begin
      nxt_dev = dev + 1'b1;
      nxt_fn  = '0;
    end else begin
      nxt_dev = dev;
      nxt_fn  = fn + 1'b1;
    end
  end

endmodule

// File: rtl/bus_enum_engine.sv
module bus_enum_engine
  import bus_enum_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int BUS_W       = 8,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             req_valid,
  output logic             req_write,
  output logic [BUS_W-1:0] req_bus,
  output logic [DEV_W-1:0] req_dev,
  output logic [FN_W-1:0]  req_fn,
  output logic [OFF_W-1:0] req_off,
  output logic [BUS_W-1:0] req_wdata,
  input  logic             rsp_valid,
  input  logic [STS_W-1:0] rsp_status,
  input  logic [DAT_W-1:0] rsp_data,
  output logic             done,
  output logic             err_overflow,
  output logic [CNT_W-1:0] func_count,
  output logic [BUS_W-1:0] max_bus
);
  typedef struct packed {
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic             mf;
  } ctx_t;
  localparam int CTX_W = $bits(ctx_t);

  scan_st_e         st_q, st_d;
  ctx_t             ctx_q, ctx_d;
  logic             pend_q, pend_d;
  logic             absent_q, absent_d;
  logic [BUS_W-1:0] max_q, max_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             done_q, done_d;

  logic             stk_clear, stk_push, stk_pop, stk_empty, stk_full;
  logic [CTX_W-1:0] stk_top;
  ctx_t             popped;

  logic             skip_rest, bus_end;
  logic [DEV_W-1:0] nxt_dev;
  logic [FN_W-1:0]  nxt_fn;

  logic             issuing, rsp_ok, rsp_retry, vid_present, is_bridge;

  bus_enum_stack #(
    .DEPTH (STACK_DEPTH),
    .W     (CTX_W)
  ) stack_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (stk_clear),
    .push  (stk_push),
    .pop   (stk_pop),
    .din   (ctx_q),
    .top   (stk_top),
    .empty (stk_empty),
    .full  (stk_full)
  );

  assign popped    = ctx_t'(stk_top);
  assign skip_rest = (ctx_q.fn == '0) && (absent_q || !ctx_q.mf);

  bus_enum_slot_walk walk_i (
    .dev       (ctx_q.dev),
    .fn        (ctx_q.fn),
    .skip_rest (skip_rest),
    .nxt_dev   (nxt_dev),
    .nxt_fn    (nxt_fn),
    .bus_end   (bus_end)
  );

  // Request port
  always_comb begin
    issuing = (st_q == ST_VID) || (st_q == ST_HDR) || (st_q == ST_PRI) ||
              (st_q == ST_SEC) || (st_q == ST_SUB_OPEN) || (st_q == ST_SUB_CLOSE);
    req_valid = issuing && !pend_q;
    req_write = (st_q != ST_VID) && (st_q != ST_HDR);
    req_bus   = ctx_q.bus;
    req_dev   = ctx_q.dev;
    req_fn    = ctx_q.fn;
    case (st_q)
      ST_HDR:       begin req_off = OFF_HTYPE;  req_wdata = '0;        end
      ST_PRI:       begin req_off = OFF_PRIM;   req_wdata = ctx_q.bus; end
      ST_SEC:       begin req_off = OFF_SECB;   req_wdata = max_q;     end
      ST_SUB_OPEN:  begin req_off = OFF_SUBB;   req_wdata = '1;        end
      ST_SUB_CLOSE: begin req_off = OFF_SUBB;   req_wdata = max_q;     end
      default:      begin req_off = OFF_VENDOR; req_wdata = '0;        end
    endcase
  end

  assign rsp_ok      = rsp_valid && pend_q && (rsp_status != CPL_RETRY);
  assign rsp_retry   = rsp_valid && pend_q && (rsp_status == CPL_RETRY);
  assign vid_present = (rsp_status == CPL_OK) && (rsp_data != VENDOR_NONE);
  assign is_bridge   = (rsp_data[6:0] == HTYPE_BRIDGE);

  // Next state
  always_comb begin
    st_d      = st_q;
    ctx_d     = ctx_q;
    absent_d  = absent_q;
    max_d     = max_q;
    cnt_d     = cnt_q;
    err_d     = err_q;
    done_d    = done_q;
    stk_clear = 1'b0;
    stk_push  = 1'b0;
    stk_pop   = 1'b0;

    pend_d = pend_q;
    if (req_valid) begin
      pend_d = 1'b1;
    end else if (rsp_ok || rsp_retry) begin
      pend_d = 1'b0;
    end

    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          st_d      = ST_VID;
          ctx_d     = '0;
          absent_d  = 1'b0;
          max_d     = '0;
          cnt_d     = '0;
          err_d     = 1'b0;
          done_d    = 1'b0;
          stk_clear = 1'b1;
        end
      end
      ST_VID: begin
        if (rsp_ok) begin
          if (vid_present) begin
            cnt_d = cnt_q + 1'b1;
            st_d  = ST_HDR;
          end else begin
            absent_d = 1'b1;
            st_d     = ST_ADV;
          end
        end
      end
      ST_HDR: begin
        if (rsp_ok) begin
          if (ctx_q.fn == '0) begin
            ctx_d.mf = rsp_data[7];
          end
          if (is_bridge) begin
            max_d = max_q + 1'b1;
            st_d  = ST_PRI;
          end else begin
            st_d = ST_ADV;
          end
        end
      end
      ST_PRI: begin
        if (rsp_ok) st_d = ST_SEC;
      end
      ST_SEC: begin
        if (rsp_ok) st_d = ST_SUB_OPEN;
      end
      ST_SUB_OPEN: begin
        if (rsp_ok) begin
          if (stk_full) begin
            err_d = 1'b1;
            st_d  = ST_SUB_CLOSE;
          end else begin
            stk_push  = 1'b1;
            ctx_d.bus = max_q;
            ctx_d.dev = '0;
            ctx_d.fn  = '0;
            ctx_d.mf  = 1'b0;
            absent_d  = 1'b0;
            st_d      = ST_VID;
          end
        end
      end
      ST_SUB_CLOSE: begin
        if (rsp_ok) st_d = ST_ADV;
      end
      ST_ADV: begin
        absent_d = 1'b0;
        if (bus_end) begin
          if (stk_empty) begin
            done_d = 1'b1;
            st_d   = ST_DONE;
          end else begin
            stk_pop = 1'b1;
            ctx_d   = popped;
            st_d    = ST_SUB_CLOSE;
          end
        end else begin
          ctx_d.dev = nxt_dev;
          ctx_d.fn  = nxt_fn;
          st_d      = ST_VID;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ctx_q    <= '0;
      pend_q   <= 1'b0;
      absent_q <= 1'b0;
      max_q    <= '0;
      cnt_q    <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      ctx_q    <= ctx_d;
      pend_q   <= pend_d;
      absent_q <= absent_d;
      max_q    <= max_d;
      cnt_q    <= cnt_d;
      err_q    <= err_d;
      done_q   <= done_d;
    end
  end

  assign done         = done_q;
  assign err_overflow = err_q;
  assign func_count   = cnt_q;
  assign max_bus      = max_q;

endmodule

// File: rtl/bus_enum_engine_chk.sv
module bus_enum_engine_chk
  import bus_enum_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             req_valid,
  input logic             req_write,
  input logic [BUS_W-1:0] req_bus,
  input logic [OFF_W-1:0] req_off,
  input logic [BUS_W-1:0] req_wdata,
  input logic             done,
  input logic             err_overflow,
  input logic [BUS_W-1:0] max_bus
);

  // R9: a request strobe never lasts two cycles
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  // R9: done holds until restarted and the port stays quiet
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r9_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R9: writes only target the three bus-number bytes
  a_r9_write_offsets: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |->
      ((req_off == OFF_PRIM) || (req_off == OFF_SECB) || (req_off == OFF_SUBB)));

  // R5: the secondary byte is the freshly assigned highest bus
  a_r5_sec_is_max: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && (req_off == OFF_SECB)) |-> (req_wdata == max_bus));

  // R6: highest bus never drops during a scan and bounds every request
  a_r6_max_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (max_bus >= $past(max_bus)));

  a_r6_bus_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bus <= max_bus));

  // R8: overflow flag is sticky until the next start
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overflow && !start) |=> err_overflow);

endmodule

bind bus_enum_engine bus_enum_engine_chk #(.BUS_W(BUS_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_bus      (req_bus),
  .req_off      (req_off),
  .req_wdata    (req_wdata),
  .done         (done),
  .err_overflow (err_overflow),
  .max_bus      (max_bus)
);

// File: tb/bus_enum_engine_tb_top.sv
module bus_enum_engine_tb_top;
  import bus_enum_pkg::*;

  localparam int NMAX = 16;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        req_valid, req_write;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic [7:0]  req_off;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [2:0]  rsp_status;
  logic [15:0] rsp_data;
  logic        done, err_overflow;
  logic [15:0] func_count;
  logic [7:0]  max_bus;

  int n_vec;
  int n_bad;

  // topology model: parent index (-1 = bus 0), slot, kind, programmed bytes
  int n_cnt;
  int nd_par [NMAX];
  int nd_dev [NMAX];
  int nd_fn  [NMAX];
  int nd_br  [NMAX];
  int nd_mf  [NMAX];
  int nd_pri [NMAX];
  int nd_sec [NMAX];
  int nd_sub [NMAX];
  int nd_sub_first [NMAX];
  int retry_node;
  int retry_left;
  int retry_reads;

  bus_enum_engine dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_bus      (req_bus),
    .req_dev      (req_dev),
    .req_fn       (req_fn),
    .req_off      (req_off),
    .req_wdata    (req_wdata),
    .rsp_valid    (rsp_valid),
    .rsp_status   (rsp_status),
    .rsp_data     (rsp_data),
    .done         (done),
    .err_overflow (err_overflow),
    .func_count   (func_count),
    .max_bus      (max_bus)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_topo();
    n_cnt      = 0;
    retry_node = -1;
    retry_left = 0;
    retry_reads = 0;
  endtask

  function automatic int add_node(int par, int dev, int fn, int br, int mf);
    int i;
    i = n_cnt;
    nd_par[i] = par; nd_dev[i] = dev; nd_fn[i] = fn;
    nd_br[i] = br;   nd_mf[i] = mf;
    nd_pri[i] = -1;  nd_sec[i] = -1; nd_sub[i] = -1; nd_sub_first[i] = -1;
    n_cnt = n_cnt + 1;
    return i;
  endfunction

  function automatic int lookup(int bus, int dev, int fn);
    int pb;
    for (int i = 0; i < n_cnt; i++) begin
      pb = (nd_par[i] < 0) ? 0 : nd_sec[nd_par[i]];
      if (pb == bus && nd_dev[i] == dev && nd_fn[i] == fn) return i;
    end
    return -1;
  endfunction

  // completer model
  initial begin
    int idx;
    rsp_valid  = 1'b0;
    rsp_status = 3'b000;
    rsp_data   = 16'h0000;
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rst_n && req_valid) begin
        idx = lookup(int'(req_bus), int'(req_dev), int'(req_fn));
        rsp_status = CPL_OK;
        rsp_data   = 16'h0000;
        if (!req_write) begin
          if (req_off == OFF_VENDOR) begin
            if (idx >= 0 && idx == retry_node) retry_reads++;
            if (idx >= 0 && idx == retry_node && retry_left > 0) begin
              retry_left--;
              rsp_status = CPL_RETRY;
              rsp_data   = 16'hFFFF;
            end else begin
              rsp_data = (idx < 0) ? 16'hFFFF : 16'h1AB3;
            end
          end else begin
            rsp_data = (idx < 0) ? 16'h0000 :
                       {8'h00, 1'(nd_mf[idx]), 6'b0, 1'(nd_br[idx])};
          end
        end else if (idx >= 0) begin
          case (req_off)
            OFF_PRIM: nd_pri[idx] = int'(req_wdata);
            OFF_SECB: nd_sec[idx] = int'(req_wdata);
            OFF_SUBB: begin
              if (nd_sub_first[idx] < 0) nd_sub_first[idx] = int'(req_wdata);
              nd_sub[idx] = int'(req_wdata);
            end
            default: ;
          endcase
        end
        @(negedge clk);
        rsp_valid = 1'b1;
      end
    end
  end

  task automatic run_scan(input string req);
    int waited;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    n_vec++;
    if (!done) begin
      n_bad++;
      $display("FAIL %s: watchdog, actual done 0 expected 1", req);
    end
  endtask

  task automatic t_reset_state();
    check("R1 done after reset", int'(done), 0);
    check("R1 count after reset", int'(func_count), 0);
    check("R1 max_bus after reset", int'(max_bus), 0);
    check("R1 err after reset", int'(err_overflow), 0);
    repeat (5) begin
      @(negedge clk);
      check("R1 no request while idle", int'(req_valid), 0);
    end
  endtask

  task automatic t_flat();
    int n;
    clear_topo();
    n = add_node(-1, 0, 0, 0, 0);
    n = add_node(-1, 3, 0, 0, 1);
    n = add_node(-1, 3, 2, 0, 0);
    n = add_node(-1, 5, 0, 0, 0);
    n = add_node(-1, 5, 1, 0, 0);   // ghost behind single-function device
    n = add_node(-1, 7, 1, 0, 0);   // orphan, function 0 absent
    n = add_node(-1, 31, 0, 0, 1);
    n = add_node(-1, 31, 7, 0, 0);
    run_scan("R2 flat");
    // R2: 0/0, 3/0, 3/2, 5/0, 31/0, 31/7 ; R3 orphan and R4 ghost excluded
    check("R2 R3 R4 flat function count", int'(func_count), 6);
    check("R2 flat max_bus", int'(max_bus), 0);
    check("R8 flat no overflow", int'(err_overflow), 0);
    repeat (4) begin
      @(negedge clk);
      check("R9 quiet while done", int'(req_valid), 0);
    end
    check("R9 done holds", int'(done), 1);
  endtask

  task automatic t_hier();
    int a, b, c, d, e, n;
    clear_topo();
    a = add_node(-1, 0, 0, 1, 0);
    b = add_node(a, 0, 0, 1, 0);
    c = add_node(a, 1, 0, 1, 0);
    d = add_node(a, 2, 0, 1, 0);
    n = add_node(b, 0, 0, 0, 0);
    n = add_node(c, 0, 0, 0, 0);
    e = add_node(d, 0, 0, 1, 0);
    n = add_node(e, 0, 0, 0, 0);
    n = add_node(-1, 1, 0, 0, 0);
    run_scan("R5 hierarchy");
    check("R5 hier count", int'(func_count), 9);
    check("R6 hier max_bus", int'(max_bus), 5);
    check("R5 A primary", nd_pri[a], 0);
    check("R5 A secondary", nd_sec[a], 1);
    check("R6 A subordinate", nd_sub[a], 5);
    check("R5 B secondary", nd_sec[b], 2);
    check("R6 B subordinate", nd_sub[b], 2);
    check("R5 C primary", nd_pri[c], 1);
    check("R5 C secondary", nd_sec[c], 3);
    check("R6 C subordinate", nd_sub[c], 3);
    check("R5 D secondary", nd_sec[d], 4);
    check("R6 D subordinate", nd_sub[d], 5);
    check("R5 E primary", nd_pri[e], 4);
    check("R5 E secondary", nd_sec[e], 5);
    check("R6 E subordinate", nd_sub[e], 5);
    check("R5 A first subordinate FFh", nd_sub_first[a], 255);
    check("R5 E first subordinate FFh", nd_sub_first[e], 255);
    check("R8 hier no overflow", int'(err_overflow), 0);
  endtask

  task automatic t_overflow();
    int br [5];
    int n;
    clear_topo();
    br[0] = add_node(-1, 0, 0, 1, 0);
    for (int k = 1; k < 5; k++) br[k] = add_node(br[k-1], 0, 0, 1, 0);
    n = add_node(br[4], 0, 0, 0, 0);   // hidden by full stack
    run_scan("R8 overflow");
    check("R8 overflow count", int'(func_count), 5);
    check("R8 overflow max_bus", int'(max_bus), 5);
    check("R8 overflow flag", int'(err_overflow), 1);
    check("R8 deepest secondary", nd_sec[br[4]], 5);
    check("R8 deepest subordinate", nd_sub[br[4]], 5);
    check("R8 deepest first subordinate", nd_sub_first[br[4]], 255);
    check("R6 outer subordinate", nd_sub[br[0]], 5);
  endtask

  task automatic t_retry();
    int n;
    clear_topo();
    n = add_node(-1, 2, 0, 0, 0);
    retry_node = n;
    retry_left = 2;
    run_scan("R7 retry");
    check("R7 retried function counted", int'(func_count), 1);
    check("R7 vendor reads issued", retry_reads, 3);
    check("R7 retries consumed", retry_left, 0);
  endtask

  task automatic t_restart();
    t_flat();
    check("R1 restart clears overflow", int'(err_overflow), 0);
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    start = 1'b0;
    rst_n = 1'b0;
    clear_topo();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_flat();
    t_hier();
    t_overflow();
    t_retry();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule